// File: doc/BRIEF.md
# USB Endpoint Bank Error Monitor

This block holds the single data bank of one USB device endpoint and watches for transfer exceptions on it. A packet-level protocol engine talks to one side: it raises IN token requests, and for OUT transfers it delivers a start strobe, a stream of data bytes and an end strobe that carries a received-CRC-bad indication. A CPU-side port on the other side fills the bank for IN transfers, drains it for OUT transfers, and releases a received OUT packet once it has been consumed.

The block keeps the bank fill count, a transmit-bank-free status, a received-OUT status and an access-allowed status for the CPU. It also keeps three sticky exception flags: underflow, overflow and CRC error. Which flags may be raised depends on the endpoint type. An overflowed or corrupted OUT packet is still kept and reported as received. The endpoint interrupt is the OR of the flags whose enable bits are set.

Top module: `usbep_bank_mon`

## Requirements
- R1: After reset the bank count, received-OUT status, transmit strobes, error flags and interrupt are all zero.
- R2: The bank capacity is `cfg_size` when it lies in 1..BANK_BYTES and BANK_BYTES otherwise. On an IN endpoint (`cfg_dir_in`=1) each `cpu_wr` cycle stores one byte while the count is below capacity, and `cpu_access_ok` equals (count < capacity). Writes made when the bank is full are ignored, and so are writes made in the same cycle as an IN token.
- R3: An IN token on a non-empty IN bank pulses `tx_vld` one cycle later with `tx_len` equal to the count, and the bank is emptied.
- R4: An IN token on an empty IN bank pulses `tx_vld` with `tx_len`=0. On an isochronous endpoint (`cfg_type`=2'b01) it sets the underflow flag (`err_flags[0]`) and pulses `tx_zlp`. On any other type it pulses `tx_nak` and sets no flag.
- R5: On an OUT endpoint, the end strobe of an accepted packet sets `rx_ready`, and `bank_cnt` holds the stored byte count. While `rx_ready` is set and unread bytes remain, `cpu_access_ok` is high and `cpu_rdata` presents the stored bytes in arrival order, one per `cpu_rd`. `cpu_ack` clears `rx_ready` and empties the bank.
- R6: An OUT start strobe that arrives while `rx_ready` is set discards the whole packet and leaves the bank unchanged. It sets the underflow flag only on an isochronous endpoint.
- R7: For every endpoint type, an OUT packet longer than the capacity keeps its first capacity-many bytes, still sets `rx_ready`, and sets the overflow flag (`err_flags[1]`) at its end strobe.
- R8: A packet ending with `out_crc_bad`=1 is stored and sets `rx_ready` as normal. It sets the CRC flag (`err_flags[2]`) only on an isochronous endpoint.
- R9: Each error flag stays set until its `err_clr` bit is pulsed. When a clear and a new event for the same flag fall in one cycle, the flag ends up set.
- R10: `ep_irq` is high exactly when some flag is set and its bit in `irq_en` is one.
- R11: Strobes for the opposite direction have no effect: `cpu_wr`, `in_tok` on OUT endpoints, and the OUT packet strobes on IN endpoints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_type | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_size | input | CW | Bank capacity in bytes (0 or out of range selects BANK_BYTES) |
| irq_en | input | 3 | Interrupt enables, one bit per error flag |
| in_tok | input | 1 | Host IN token strobe |
| out_sop | input | 1 | OUT packet start strobe |
| out_byte_vld | input | 1 | OUT data byte valid |
| out_byte | input | DW | OUT data byte |
| out_eop | input | 1 | OUT packet end strobe |
| out_crc_bad | input | 1 | Received CRC was bad, qualified by out_eop |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_wdata | input | DW | CPU write data |
| cpu_rd | input | 1 | CPU byte read strobe |
| cpu_ack | input | 1 | CPU releases a received OUT packet |
| err_clr | input | 3 | Per-flag clear strobes |
| cpu_rdata | output | DW | Byte at the CPU read position |
| tx_vld | output | 1 | IN response strobe |
| tx_len | output | CW | IN response length |
| tx_zlp | output | 1 | Response is an automatic zero-length packet |
| tx_nak | output | 1 | Response is a NAK (empty, non-isochronous) |
| cpu_access_ok | output | 1 | CPU may write (IN) or read (OUT) now |
| tx_bank_free | output | 1 | IN bank is empty |
| rx_ready | output | 1 | A received OUT packet is waiting |
| bank_cnt | output | CW | Bytes held in the bank |
| err_flags | output | 3 | Sticky flags: [0] underflow, [1] overflow, [2] CRC error |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
A wrong fill count shows up at `bank_cnt` and `cpu_access_ok` on the clock edge after the offending write or byte, and in `tx_len` one cycle after the next IN token. A lost or corrupted read position shows in `cpu_rdata` as soon as the CPU starts draining. A pending-packet state that was never cleared, or was cleared too early, shows at the next OUT start strobe: data gets overwritten, or the underflow flag is wrong, one cycle after that strobe. Flag faults reach `err_flags` and `ep_irq` one edge after the event or the clear, and the sweep over every type, size and length crosses each such condition.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
   localparam int N_ERR  = 3;
   localparam int E_UNDER = 0;
   localparam int E_OVER  = 1;
   localparam int E_CRC   = 2;

   typedef enum logic [1:0] {
      EP_CTRL = 2'b00,
      EP_ISO  = 2'b01,
      EP_BULK = 2'b10,
      EP_INTR = 2'b11
   } ep_type_e;
endpackage

// File: rtl/usbep_bank_store.sv
module usbep_bank_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [DW-1:0]              push_data,
   input  logic                       pop,
   output logic [DW-1:0]              rd_data,
   output logic [$clog2(DEPTH+1)-1:0] cnt,
   output logic [$clog2(DEPTH+1)-1:0] rd_ptr
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int AW = $clog2(DEPTH);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         rd_ptr <= '0;
      end else if (clr) begin
         cnt    <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) cnt    <= cnt + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[cnt[AW-1:0]] <= push_data;
   end

   assign rd_data = mem[rd_ptr[AW-1:0]];

   AST_STORE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |-> (cnt < DEPTH_C)); // R2
   AST_STORE_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> (rd_ptr < cnt)); // R5
endmodule

// File: rtl/usbep_err_flags.sv
module usbep_err_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]); // R9
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]); // R9
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr[i] && !set[i]) |=> (flags[i] == $past(flags[i]))); // R9
   end

   assign irq = |(flags & en);
endmodule

// File: rtl/usbep_bank_mon.sv
module usbep_bank_mon
   import usbep_pkg::*;
#(
   parameter int BANK_BYTES = 8,
   parameter int DW         = 8,
   parameter int CW         = $clog2(BANK_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_type,
   input  logic          cfg_dir_in,
   input  logic [CW-1:0] cfg_size,
   input  logic [2:0]    irq_en,
   input  logic          in_tok,
   input  logic          out_sop,
   input  logic          out_byte_vld,
   input  logic [DW-1:0] out_byte,
   input  logic          out_eop,
   input  logic          out_crc_bad,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cpu_rd,
   input  logic          cpu_ack,
   input  logic [2:0]    err_clr,
   output logic [DW-1:0] cpu_rdata,
   output logic          tx_vld,
   output logic [CW-1:0] tx_len,
   output logic          tx_zlp,
   output logic          tx_nak,
   output logic          cpu_access_ok,
   output logic          tx_bank_free,
   output logic          rx_ready,
   output logic [CW-1:0] bank_cnt,
   output logic [2:0]    err_flags,
   output logic          ep_irq
);
   localparam logic [CW-1:0] DEPTH_C = CW'(BANK_BYTES);

   if (BANK_BYTES < 2) begin : g_bad_depth
      $error("usbep_bank_mon: BANK_BYTES must be at least 2");
   end
   if (CW != $clog2(BANK_BYTES + 1)) begin : g_bad_cw
      $error("usbep_bank_mon: CW must match BANK_BYTES");
   end
   if (N_ERR != 3) begin : g_bad_nerr
      $error("usbep_bank_mon: flag vector width mismatch");
   end

   logic [CW-1:0] cap, cnt, rd_ptr;
   logic          iso, is_in, empty, full;
   logic          tok_v, sop_v, byte_v, eop_v, ack_v, wr_v, rd_v;
   logic          accepting, ovf_pend, rx_pend;
   logic          st_clr, st_push;
   logic [DW-1:0] st_data;
   logic [2:0]    ev_set;

   assign iso   = (cfg_type == EP_ISO);
   assign is_in = cfg_dir_in;
   assign cap   = (cfg_size == '0 || cfg_size > DEPTH_C) ? DEPTH_C : cfg_size;
   assign empty = (cnt == '0);
   assign full  = (cnt >= cap);

   // direction-qualified strobes
   assign tok_v  = in_tok && is_in;
   assign sop_v  = out_sop && !is_in;
   assign byte_v = out_byte_vld && !is_in && accepting;
   assign eop_v  = out_eop && !is_in && accepting;
   assign ack_v  = cpu_ack && !is_in && rx_pend;
   assign wr_v   = cpu_wr && is_in && !full && !tok_v;
   assign rd_v   = cpu_rd && cpu_access_ok && !is_in;

   assign cpu_access_ok = is_in ? !full : (rx_pend && (rd_ptr < cnt));
   assign tx_bank_free  = is_in && empty;
   assign rx_ready      = rx_pend;
   assign bank_cnt      = cnt;

   assign st_clr  = (tok_v && !empty) || (sop_v && !rx_pend) || ack_v;
   assign st_push = wr_v || (byte_v && !full);
   assign st_data = is_in ? cpu_wdata : out_byte;

   usbep_bank_store #(.DEPTH(BANK_BYTES), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (st_clr),
      .push      (st_push),
      .push_data (st_data),
      .pop       (rd_v),
      .rd_data   (cpu_rdata),
      .cnt       (cnt),
      .rd_ptr    (rd_ptr)
   );

   // OUT packet reception state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accepting <= 1'b0;
         ovf_pend  <= 1'b0;
         rx_pend   <= 1'b0;
      end else begin
         if (sop_v) begin
            accepting <= !rx_pend;
            if (!rx_pend) ovf_pend <= 1'b0;
         end else if (eop_v) begin
            accepting <= 1'b0;
         end
         if (byte_v && full) ovf_pend <= 1'b1;
         if (eop_v)          rx_pend  <= 1'b1;
         else if (ack_v)     rx_pend  <= 1'b0;
      end
   end

   // IN response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_vld <= 1'b0;
         tx_len <= '0;
         tx_zlp <= 1'b0;
         tx_nak <= 1'b0;
      end else begin
         tx_vld <= tok_v;
         tx_len <= tok_v ? cnt : '0;
         tx_zlp <= tok_v && empty && iso;
         tx_nak <= tok_v && empty && !iso;
      end
   end

   assign ev_set[E_UNDER] = iso && ((tok_v && empty) || (sop_v && rx_pend));
   assign ev_set[E_OVER]  = eop_v && ovf_pend;
   assign ev_set[E_CRC]   = eop_v && iso && out_crc_bad;

   usbep_err_flags #(.N(N_ERR)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .clr   (err_clr),
      .en    (irq_en),
      .flags (err_flags),
      .irq   (ep_irq)
   );

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C); // R2
   AST_TX_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
      tok_v |=> tx_vld); // R3
   AST_ZLP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_zlp |-> (tx_vld && tx_len == '0)); // R4
   AST_RX_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      eop_v |=> rx_ready); // R5
   AST_UNDER_ISO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_UNDER]) |-> $past(iso)); // R6
   AST_DROP_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_v && rx_pend && !cpu_rd && !cpu_ack) |=> $stable(bank_cnt)); // R6
   AST_CRC_ISO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_CRC]) |-> $past(iso)); // R8
   AST_IN_IGNORES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in && $past(is_in)) |-> !rx_ready || $past(rx_ready)); // R11
endmodule

// File: tb/sim_usbep_bank_mon.sv
`timescale 1ns/1ps
module sim_usbep_bank_mon;
   localparam int BB = 4;
   localparam int CW = $clog2(BB + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    cfg_type;
   logic          cfg_dir_in;
   logic [CW-1:0] cfg_size;
   logic [2:0]    irq_en;
   logic          in_tok, out_sop, out_byte_vld, out_eop, out_crc_bad;
   logic [7:0]    out_byte, cpu_wdata, cpu_rdata;
   logic          cpu_wr, cpu_rd, cpu_ack;
   logic [2:0]    err_clr, err_flags;
   logic          tx_vld, tx_zlp, tx_nak, cpu_access_ok, tx_bank_free, rx_ready, ep_irq;
   logic [CW-1:0] tx_len, bank_cnt;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   usbep_bank_mon #(.BANK_BYTES(BB)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_dir_in(cfg_dir_in),
      .cfg_size(cfg_size), .irq_en(irq_en), .in_tok(in_tok), .out_sop(out_sop),
      .out_byte_vld(out_byte_vld), .out_byte(out_byte), .out_eop(out_eop),
      .out_crc_bad(out_crc_bad), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_ack(cpu_ack), .err_clr(err_clr), .cpu_rdata(cpu_rdata),
      .tx_vld(tx_vld), .tx_len(tx_len), .tx_zlp(tx_zlp), .tx_nak(tx_nak),
      .cpu_access_ok(cpu_access_ok), .tx_bank_free(tx_bank_free), .rx_ready(rx_ready),
      .bank_cnt(bank_cnt), .err_flags(err_flags), .ep_irq(ep_irq)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_all();
      in_tok = 0; out_sop = 0; out_byte_vld = 0; out_byte = 0; out_eop = 0;
      out_crc_bad = 0; cpu_wr = 0; cpu_wdata = 0; cpu_rd = 0; cpu_ack = 0; err_clr = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      idle_all();
      tick(); tick();
      rst_n = 1;
      tick();
   endtask

   task automatic send_out(int len, bit bad, int base);
      out_sop = 1; tick(); out_sop = 0;
      for (int i = 0; i < len; i++) begin
         out_byte_vld = 1; out_byte = 8'(base + i); tick();
      end
      out_byte_vld = 0;
      out_eop = 1; out_crc_bad = bad; tick();
      out_eop = 0; out_crc_bad = 0;
   endtask

   task automatic cpu_write(int n, int base);
      for (int i = 0; i < n; i++) begin
         cpu_wr = 1; cpu_wdata = 8'(base + i); tick();
      end
      cpu_wr = 0;
   endtask

   initial begin
      cfg_type = 2'b00; cfg_dir_in = 1; cfg_size = '0; irq_en = 3'b000;
      do_reset();
      // R1 reset state
      check("R1 bank_cnt", int'(bank_cnt), 0);
      check("R1 rx_ready", int'(rx_ready), 0);
      check("R1 err_flags", int'(err_flags), 0);
      check("R1 ep_irq", int'(ep_irq), 0);
      check("R1 tx_vld", int'(tx_vld), 0);

      // IN endpoint sweep
      for (int typ = 0; typ < 4; typ++) begin
         for (int sz = 0; sz < 2; sz++) begin
            for (int k = 0; k < 6; k++) begin
               int cap, n;
               bit iso;
               iso = (typ == 1);
               cap = (sz == 0) ? BB : 2;
               n = (k < cap) ? k : cap;
               cfg_type = 2'(typ); cfg_dir_in = 1; cfg_size = (sz == 0) ? '0 : CW'(2);
               do_reset();
               cpu_write(k, 8'h10);
               check("R2 count after writes", int'(bank_cnt), n);
               check("R2 access ok", int'(cpu_access_ok), int'(n < cap));
               check("R2 bank free", int'(tx_bank_free), int'(n == 0));
               if (k == 2) begin
                  send_out(3, 1'b1, 8'h30);
                  check("R11 out strobes on IN count", int'(bank_cnt), n);
                  check("R11 out strobes on IN rx_ready", int'(rx_ready), 0);
                  check("R11 out strobes on IN flags", int'(err_flags), 0);
               end
               in_tok = 1; tick(); in_tok = 0;
               check("R3 tx_vld", int'(tx_vld), 1);
               check("R3 tx_len", int'(tx_len), n);
               check("R4 tx_zlp", int'(tx_zlp), int'(iso && n == 0));
               check("R4 tx_nak", int'(tx_nak), int'(!iso && n == 0));
               check("R4 underflow", int'(err_flags[0]), int'(iso && n == 0));
               check("R3 bank emptied", int'(bank_cnt), 0);
               tick();
               check("R3 tx_vld single", int'(tx_vld), 0);
            end
         end
      end

      // OUT endpoint sweep
      for (int typ = 0; typ < 4; typ++) begin
         for (int sz = 0; sz < 2; sz++) begin
            for (int len = 0; len < 7; len++) begin
               for (int bad = 0; bad < 2; bad++) begin
                  int cap, n, base;
                  bit iso;
                  iso = (typ == 1);
                  cap = (sz == 0) ? BB : 2;
                  n = (len < cap) ? len : cap;
                  base = 8'h40 + len * 8;
                  cfg_type = 2'(typ); cfg_dir_in = 0; cfg_size = (sz == 0) ? '0 : CW'(2);
                  do_reset();
                  send_out(len, bit'(bad), base);
                  check("R5 rx_ready", int'(rx_ready), 1);
                  check("R7 stored count", int'(bank_cnt), n);
                  check("R7 overflow", int'(err_flags[1]), int'(len > cap));
                  check("R8 crc flag", int'(err_flags[2]), int'(iso && bad == 1));
                  check("R6 no underflow yet", int'(err_flags[0]), 0);
                  send_out(3, 1'b0, 8'hC0);
                  check("R6 underflow on busy bank", int'(err_flags[0]), int'(iso));
                  check("R6 bank unchanged", int'(bank_cnt), n);
                  cpu_wr = 1; cpu_wdata = 8'hEE; tick(); cpu_wr = 0;
                  check("R11 cpu_wr on OUT", int'(bank_cnt), n);
                  in_tok = 1; tick(); in_tok = 0;
                  check("R11 in_tok on OUT", int'(tx_vld), 0);
                  for (int j = 0; j < n; j++) begin
                     check("R5 access ok while unread", int'(cpu_access_ok), 1);
                     check("R5 read data", int'(cpu_rdata), (base + j) & 8'hFF);
                     cpu_rd = 1; tick(); cpu_rd = 0;
                  end
                  check("R5 access off when drained", int'(cpu_access_ok), 0);
                  cpu_ack = 1; tick(); cpu_ack = 0;
                  check("R5 ack clears rx_ready", int'(rx_ready), 0);
                  check("R5 ack empties bank", int'(bank_cnt), 0);
               end
            end
         end
      end

      // R9 / R10: flags, clears and interrupt
      cfg_type = 2'b01; cfg_dir_in = 0; cfg_size = '0;
      do_reset();
      send_out(6, 1'b1, 8'h00);
      send_out(1, 1'b0, 8'h00);
      check("R9 all flags set", int'(err_flags), 7);
      for (int e = 0; e < 8; e++) begin
         irq_en = 3'(e);
         tick();
         check("R10 irq all flags", int'(ep_irq), int'(e != 0));
      end
      repeat (3) tick();
      check("R9 flags sticky", int'(err_flags), 7);
      err_clr = 3'b010; tick(); err_clr = 0;
      check("R9 selective clear", int'(err_flags), 5);
      for (int e = 0; e < 8; e++) begin
         irq_en = 3'(e);
         tick();
         check("R10 irq masked", int'(ep_irq), int'((e & 5) != 0));
      end
      // new underflow event and its clear in the same cycle
      out_sop = 1; err_clr = 3'b001; tick(); out_sop = 0; err_clr = 0;
      out_eop = 1; tick(); out_eop = 0;
      check("R9 event wins over clear", int'(err_flags[0]), 1);
      err_clr = 3'b101; tick(); err_clr = 0;
      check("R9 clear after", int'(err_flags), 0);
      irq_en = 3'b111; tick();
      check("R10 irq low with no flags", int'(ep_irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule